// File: doc/BRIEF.md
# Configuration Store with Security Lock

This block keeps the configuration of a small programmable logic array: a word-addressed fuse map, an eight-byte user signature and a one-way security bit. It also owns the preload path into the bank of macrocell registers, so that a test sequence can force any register pattern before normal clocking resumes. All access goes through one synchronous command port. Each command carries an opcode, an address and a data byte. The block accepts a command only while it is idle and closes each one with a single-cycle done pulse that carries the response.

Once the security bit is set, reading back the fuse map and preloading the macrocell registers are both refused. The user signature stays readable and writable. The only way to clear the lock is the erase command, which also wipes the fuse map and the signature.

The sequencer has three states. `ST_IDLE` waits for `cmd_valid` and moves to `ST_EXEC` when the command is taken. `ST_EXEC` performs the operation on the next edge and always moves to `ST_ACK`. `ST_ACK` drives `cmd_done` for one cycle and always returns to `ST_IDLE`.

Top module: `cfg_lock_store`

## Requirements
- R1: After reset the block behaves as follows:
  - `cmd_busy`, `cmd_done`, `rsp_data`, `rsp_err`, `sec_locked` and `mc_q` are all zero.
  - Every fuse word and signature byte reads as zero.
- R2: Command acceptance and completion follow this handshake:
  - A command is taken on a rising edge where `cmd_valid` is high and `cmd_busy` is low.
  - `cmd_busy` is high for the next two cycles.
  - `cmd_done` is high only in the second of those cycles, for exactly one cycle.
  - `rsp_data` and `rsp_err` are valid in that cycle.
  - Anything presented while `cmd_busy` is high is ignored.
- R3: The fuse write and verify opcodes work as follows:
  - Opcode 0 (fuse write) stores `cmd_wdata` at fuse word `cmd_addr`.
  - Opcode 1 (verify), when unlocked, returns that word on `rsp_data` with `rsp_err` low.
- R4: The signature opcodes work whether the block is locked or not:
  - Opcode 3 writes `cmd_wdata` to signature byte `cmd_addr[2:0]`.
  - Opcode 4 returns that byte with `rsp_err` low.
- R5: Opcode 2 (preload), when unlocked, loads each macrocell register from its own bit of `cmd_wdata`, high or low. The new `mc_q` is visible in the same cycle as `cmd_done`.
- R6: While `mc_step` is high and no preload is executing, `mc_q` takes `mc_d` on every clock edge. While `mc_step` is low, `mc_q` holds its value.
- R7: Opcode 5 sets `sec_locked`, which reads high in its done cycle. The lock applies from the very next command. Only erase clears it.
- R8: Verify while locked returns `rsp_data` of zero with `rsp_err` high.
- R9: Preload while locked leaves `mc_q` unchanged and raises `rsp_err`.
- R10: Opcode 6 (erase) clears the lock, every fuse word and every signature byte. After erase, preload is accepted again.
- R11: Opcode 7 is invalid. It changes no state, returns `rsp_data` of zero and raises `rsp_err`. Every valid command other than a locked verify or locked preload returns `rsp_err` low. Commands that are not reads return `rsp_data` of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Opcode (0 fuse write, 1 verify, 2 preload, 3 signature write, 4 signature read, 5 lock, 6 erase) |
| cmd_addr | input | ADDR_W (5) | Fuse word or signature byte address |
| cmd_wdata | input | DATA_W (8) | Write or preload data |
| cmd_busy | output | 1 | High while a command is in flight |
| cmd_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | DATA_W (8) | Read result |
| rsp_err | output | 1 | Command refused or invalid |
| sec_locked | output | 1 | Security bit |
| mc_step | input | 1 | Normal clock enable for the macrocell registers |
| mc_d | input | NUM_MC (8) | Next-state values from the array |
| mc_q | output | NUM_MC (8) | Macrocell register outputs |

## Verification
A sequencer stuck in or skipping a state shows up within two cycles of a command, as a missing, doubled or early `cmd_done` or a `cmd_busy` that never falls. A lock bit that sets late or clears by itself is exposed by the first verify or preload after the lock command: a readback value or a moved `mc_q` where zero and an error were due. Storage faults surface at the next read of the affected word or byte, and a failed erase shows up at the first read after it.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;

    typedef enum logic [2:0] {
        OP_FUSE_WR  = 3'd0,
        OP_FUSE_VFY = 3'd1,
        OP_PRELOAD  = 3'd2,
        OP_SIG_WR   = 3'd3,
        OP_SIG_RD   = 3'd4,
        OP_LOCK     = 3'd5,
        OP_ERASE    = 3'd6,
        OP_BAD      = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_ACK  = 2'd2
    } st_e;

endpackage

// File: rtl/cfg_cmd_fsm.sv
module cfg_cmd_fsm
    import cfg_store_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              exec,
    output op_e               op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              busy,
    output logic              done
);

    st_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_ACK;
            ST_ACK:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        exec = (state_q == ST_EXEC);
        done = (state_q == ST_ACK);
        busy = (state_q != ST_IDLE);
    end

    // command capture on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_BAD;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (state_q == ST_IDLE && cmd_valid) begin
            op_q    <= op_e'(cmd_op);
            addr_q  <= cmd_addr;
            wdata_q <= cmd_wdata;
        end
    end

endmodule

// File: rtl/cfg_store_core.sv
module cfg_store_core
    import cfg_store_pkg::*;
#(
    parameter int FUSE_WORDS = 32,
    parameter int DATA_W     = 8,
    parameter int SIG_BYTES  = 8,
    parameter int ADDR_W     = $clog2(FUSE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec,
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              err,
    output logic              locked,
    output logic              pre_fire
);

    localparam int SIG_AW = $clog2(SIG_BYTES);

    logic [DATA_W-1:0] fuse_q [FUSE_WORDS];
    logic [DATA_W-1:0] sig_q  [SIG_BYTES];
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;
    logic              lock_q;
    logic [SIG_AW-1:0] sig_idx;

    assign sig_idx  = addr[SIG_AW-1:0];
    // preload reaches the macrocells on the execute edge, only when unlocked
    assign pre_fire = exec && (op == OP_PRELOAD) && !lock_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < FUSE_WORDS; i++) fuse_q[i] <= '0;
            for (int j = 0; j < SIG_BYTES; j++)  sig_q[j]  <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
            lock_q  <= 1'b0;
        end else if (exec) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
            unique case (op)
                OP_FUSE_WR:  fuse_q[addr] <= wdata;
                OP_FUSE_VFY: begin
                    if (lock_q) err_q   <= 1'b1;
                    else        rdata_q <= fuse_q[addr];
                end
                OP_PRELOAD:  if (lock_q) err_q <= 1'b1;
                OP_SIG_WR:   sig_q[sig_idx] <= wdata;
                OP_SIG_RD:   rdata_q <= sig_q[sig_idx];
                OP_LOCK:     lock_q <= 1'b1;
                OP_ERASE: begin
                    for (int i = 0; i < FUSE_WORDS; i++) fuse_q[i] <= '0;
                    for (int j = 0; j < SIG_BYTES; j++)  sig_q[j]  <= '0;
                    lock_q <= 1'b0;
                end
                default:     err_q <= 1'b1;
            endcase
        end
    end

    assign rdata  = rdata_q;
    assign err    = err_q;
    assign locked = lock_q;

endmodule

// File: rtl/cfg_mc_bank.sv
module cfg_mc_bank #(
    parameter int NUM_MC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [NUM_MC-1:0] d,
    input  logic              pre_fire,
    input  logic [NUM_MC-1:0] pre_val,
    output logic [NUM_MC-1:0] q
);

    for (genvar i = 0; i < NUM_MC; i++) begin : g_cell
        logic cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cell_q <= 1'b0;
            else if (pre_fire) cell_q <= pre_val[i];
            else if (step)     cell_q <= d[i];
        end
        assign q[i] = cell_q;
    end

endmodule

// File: rtl/cfg_lock_store.sv
module cfg_lock_store
    import cfg_store_pkg::*;
#(
    parameter int FUSE_WORDS = 32,
    parameter int DATA_W     = 8,
    parameter int SIG_BYTES  = 8,
    parameter int NUM_MC     = 8,
    parameter int ADDR_W     = $clog2(FUSE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_busy,
    output logic              cmd_done,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_err,
    output logic              sec_locked,
    input  logic              mc_step,
    input  logic [NUM_MC-1:0] mc_d,
    output logic [NUM_MC-1:0] mc_q
);

    logic              exec_w;
    op_e               op_w;
    logic [ADDR_W-1:0] addr_w;
    logic [DATA_W-1:0] wdata_w;
    logic              pre_fire_w;

    cfg_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .exec      (exec_w),
        .op_q      (op_w),
        .addr_q    (addr_w),
        .wdata_q   (wdata_w),
        .busy      (cmd_busy),
        .done      (cmd_done)
    );

    cfg_store_core #(
        .FUSE_WORDS (FUSE_WORDS),
        .DATA_W     (DATA_W),
        .SIG_BYTES  (SIG_BYTES),
        .ADDR_W     (ADDR_W)
    ) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .exec     (exec_w),
        .op       (op_w),
        .addr     (addr_w),
        .wdata    (wdata_w),
        .rdata    (rsp_data),
        .err      (rsp_err),
        .locked   (sec_locked),
        .pre_fire (pre_fire_w)
    );

    cfg_mc_bank #(.NUM_MC(NUM_MC)) mc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (mc_step),
        .d        (mc_d),
        .pre_fire (pre_fire_w),
        .pre_val  (wdata_w[NUM_MC-1:0]),
        .q        (mc_q)
    );

endmodule

// File: rtl/cfg_lock_store_chk.sv
module cfg_lock_store_chk #(
    parameter int DATA_W = 8,
    parameter int NUM_MC = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exec,
    input logic [2:0]        op,
    input logic [DATA_W-1:0] wdata,
    input logic              cmd_busy,
    input logic              cmd_done,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_err,
    input logic              sec_locked,
    input logic              mc_step,
    input logic [NUM_MC-1:0] mc_q
);

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    a_r2_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> cmd_busy);

    a_r2_exec_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        exec |=> cmd_done);

    a_r5_preload_value: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == 3'd2 && !sec_locked) |=> (mc_q == $past(wdata[NUM_MC-1:0])));

    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_locked && !(exec && op == 3'd6)) |=> sec_locked);

    a_r8_locked_verify: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == 3'd1 && sec_locked) |=> (rsp_data == '0 && rsp_err));

    a_r9_locked_preload: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == 3'd2 && sec_locked && !mc_step) |=> ($stable(mc_q) && rsp_err));

    a_r10_erase_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == 3'd6) |=> !sec_locked);

endmodule

bind cfg_lock_store cfg_lock_store_chk #(.DATA_W(DATA_W), .NUM_MC(NUM_MC)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec       (exec_w),
    .op         (op_w),
    .wdata      (wdata_w),
    .cmd_busy   (cmd_busy),
    .cmd_done   (cmd_done),
    .rsp_data   (rsp_data),
    .rsp_err    (rsp_err),
    .sec_locked (sec_locked),
    .mc_step    (mc_step),
    .mc_q       (mc_q)
);

// File: tb/cfg_lock_store_tb_top.sv
module cfg_lock_store_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [4:0] cmd_addr = '0;
    logic [7:0] cmd_wdata = '0;
    logic       cmd_busy, cmd_done, rsp_err, sec_locked;
    logic [7:0] rsp_data;
    logic       mc_step = 1'b0;
    logic [7:0] mc_d = '0;
    logic [7:0] mc_q;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cfg_lock_store dut_i (
        .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_addr, .cmd_wdata,
        .cmd_busy, .cmd_done, .rsp_data, .rsp_err, .sec_locked,
        .mc_step, .mc_d, .mc_q
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // results captured in the done cycle
    logic [7:0] r_data;
    logic       r_err;
    logic       r_lock;
    logic [7:0] r_mc;

    task automatic run_cmd(input logic [2:0] op, input logic [4:0] addr, input logic [7:0] data);
        bit seen = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_wdata = data;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (cmd_done) begin
                seen = 1;
                r_data = rsp_data; r_err = rsp_err; r_lock = sec_locked; r_mc = mc_q;
                break;
            end
        end
        if (!seen) check(0, "R2 done missing", 0, 1);
    endtask

    task automatic t_reset();
        check(cmd_busy == 0 && cmd_done == 0, "R1 idle", {cmd_busy, cmd_done}, 0);
        check(sec_locked == 0, "R1 lock", sec_locked, 0);
        check(mc_q == 0, "R1 mc_q", mc_q, 0);
        check(rsp_data == 0 && rsp_err == 0, "R1 rsp", {rsp_err, rsp_data}, 0);
        run_cmd(3'd1, 5'd3, 8'h00);
        check(r_data == 0, "R1 fuse zero", r_data, 0);
        run_cmd(3'd4, 5'd5, 8'h00);
        check(r_data == 0, "R1 sig zero", r_data, 0);
    endtask

    task automatic t_fuse();
        run_cmd(3'd0, 5'd0, 8'h3C);
        check(r_err == 0 && r_data == 0, "R11 write rsp", {r_err, r_data}, 0);
        run_cmd(3'd0, 5'd31, 8'hC3);
        run_cmd(3'd0, 5'd7, 8'hFF);
        run_cmd(3'd1, 5'd0, 8'h00);
        check(r_data == 8'h3C && !r_err, "R3 word0", r_data, 8'h3C);
        run_cmd(3'd1, 5'd31, 8'h00);
        check(r_data == 8'hC3 && !r_err, "R3 word31", r_data, 8'hC3);
        run_cmd(3'd1, 5'd7, 8'h00);
        check(r_data == 8'hFF && !r_err, "R3 word7", r_data, 8'hFF);
    endtask

    task automatic t_handshake();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd3; cmd_addr = 5'd2; cmd_wdata = 8'h11;
        @(negedge clk);
        check(cmd_busy && !cmd_done, "R2 busy in exec", {cmd_busy, cmd_done}, 2);
        cmd_wdata = 8'h22;
        @(negedge clk);
        check(cmd_done && cmd_busy, "R2 done cycle", {cmd_busy, cmd_done}, 3);
        cmd_valid = 1'b0;
        @(negedge clk);
        check(!cmd_done && !cmd_busy, "R2 done single", {cmd_busy, cmd_done}, 0);
        run_cmd(3'd4, 5'd2, 8'h00);
        check(r_data == 8'h11, "R2 busy cmd ignored", r_data, 8'h11);
    endtask

    task automatic t_sig();
        for (int i = 0; i < 8; i++) run_cmd(3'd3, 5'(i), 8'(i * 17 + 1));
        for (int i = 0; i < 8; i++) begin
            run_cmd(3'd4, 5'(i), 8'h00);
            check(r_data == 8'(i * 17 + 1) && !r_err, "R4 sig byte", r_data, i * 17 + 1);
        end
    endtask

    task automatic t_preload();
        run_cmd(3'd2, 5'd0, 8'hA5);
        check(r_mc == 8'hA5 && !r_err, "R5 preload A5", r_mc, 8'hA5);
        run_cmd(3'd2, 5'd0, 8'h5A);
        check(r_mc == 8'h5A, "R5 preload 5A", r_mc, 8'h5A);
    endtask

    task automatic t_step();
        @(negedge clk);
        mc_d = 8'h0F; mc_step = 1'b1;
        @(negedge clk);
        check(mc_q == 8'h0F, "R6 step capture", mc_q, 8'h0F);
        mc_step = 1'b0; mc_d = 8'hF0;
        @(negedge clk);
        check(mc_q == 8'h0F, "R6 hold", mc_q, 8'h0F);
    endtask

    task automatic t_bad();
        run_cmd(3'd7, 5'd0, 8'h99);
        check(r_err && r_data == 0, "R11 bad op", {r_err, r_data}, 9'h100);
        check(r_mc == 8'h0F && !r_lock, "R11 no change", r_mc, 8'h0F);
    endtask

    task automatic t_lock();
        run_cmd(3'd5, 5'd0, 8'h00);
        check(r_lock && !r_err, "R7 lock set", r_lock, 1);
        run_cmd(3'd1, 5'd0, 8'h00);
        check(r_data == 0 && r_err, "R8 verify blocked", {r_err, r_data}, 9'h100);
        run_cmd(3'd2, 5'd0, 8'hFF);
        check(r_mc == 8'h0F && r_err, "R9 preload blocked", r_mc, 8'h0F);
        run_cmd(3'd4, 5'd3, 8'h00);
        check(r_data == 8'h34 && !r_err, "R4 sig while locked", r_data, 8'h34);
        run_cmd(3'd3, 5'd6, 8'h77);
        run_cmd(3'd4, 5'd6, 8'h00);
        check(r_data == 8'h77, "R4 sig write locked", r_data, 8'h77);
        check(r_lock, "R7 lock stays", r_lock, 1);
    endtask

    task automatic t_erase();
        run_cmd(3'd6, 5'd0, 8'h00);
        check(!r_lock && !r_err, "R10 unlock", r_lock, 0);
        run_cmd(3'd1, 5'd0, 8'h00);
        check(r_data == 0 && !r_err, "R10 fuse cleared", r_data, 0);
        run_cmd(3'd4, 5'd3, 8'h00);
        check(r_data == 0, "R10 sig cleared", r_data, 0);
        run_cmd(3'd2, 5'd0, 8'h81);
        check(r_mc == 8'h81 && !r_err, "R10 preload again", r_mc, 8'h81);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fuse();
        t_handshake();
        t_sig();
        t_preload();
        t_step();
        t_bad();
        t_lock();
        t_erase();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule